// File: doc/BRIEF.md
# Persistent Overcurrent Fault Monitor

This block watches the peak-current readings of two resolver drive channels, sine and cosine, and drives an active-high health line for a built-in-test pin. A reading counts as an overload when it is above a trip level. The health line drops only when an overload has persisted, without a single in-limit reading in between, for a programmable number of clock cycles. The default is one second at a 50 MHz clock. Brief overloads therefore never reach the pin. A hard short and a slow overload are handled the same way.

Readings arrive as a valid/ready stream carrying two unsigned milliampere words. The block never applies back-pressure. Ready rises on the first clock after reset is released and stays high, so every beat offered with valid high is taken on that edge.

After a trip, the line recovers once a set number of consecutive in-limit readings has been accepted. The block does not latch the fault. A two-bit debug output records which channel or channels were overloaded when the trip happened.

Top module: `overcurrent_monitor`

## Requirements
- R1: `s_ready` is low during reset, is high from the first clock edge after reset is released, and then stays high. A beat is accepted on an edge where `s_valid` and `s_ready` are both high. Data presented with `s_valid` low has no effect.
- R2: A channel is over limit when its reading is strictly greater than `TRIP_MA` (default 450). With the default, 450 is in limit and 451 is over. A reading over limit on either channel makes the beat an overload beat.
- R3: `health_ok` falls exactly `PERSIST_CYC` clock edges after the edge that accepts the first overload beat of a run, provided no in-limit beat is accepted in between. Further overload beats during the run do not restart the timing.
- R4: An accepted beat with both channels in limit ends any run. A run shorter than `PERSIST_CYC` cycles never changes `health_ok`.
- R5: Cycles with no accepted beat keep the last beat's classification. A run keeps timing through gaps in the stream.
- R6: While the fault is present, `health_ok` rises on the edge that accepts the `RECOVER_N`-th consecutive in-limit beat (default 4). An overload beat resets that tally. Without accepted beats the fault remains.
- R7: During reset, and until an overload has persisted, `health_ok` is 1 and `fault_src` is 0.
- R8: While the fault is present, `fault_src` holds the channel flags of the most recent accepted beat at the moment of the trip: bit 0 is sine, bit 1 is cosine. While healthy, `fault_src` is 0.
- R9: After recovery, a new trip needs a fresh overload run of the full `PERSIST_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Reading beat valid |
| s_ready | output | 1 | Block accepts beats (always high after reset) |
| sin_ma | input | CUR_W | Sine channel peak current, mA |
| cos_ma | input | CUR_W | Cosine channel peak current, mA |
| health_ok | output | 1 | 1 = normal, 0 = persistent overcurrent |
| fault_src | output | 2 | Debug: overloaded channels at trip (bit 0 sine, bit 1 cosine) |

## Verification
The bench drives a beat at a falling edge, and that beat is accepted on the following rising edge, edge a.

A trip is due on edge a + `PERSIST_CYC`. A recovery is due on the very edge that accepts the final in-limit beat.

For each stimulus, the driver places the expected `health_ok`/`fault_src` pair into a queue, stamped with the cycle number of the falling edge just after the due edge. It also places the value expected one cycle earlier. The monitor compares each queued item only when the cycle counter matches its stamp, so each check sits on the single cycle where the output is due to change.

// File: rtl/ocm_pkg.sv
package ocm_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_SIN = 0;
  localparam int CH_COS = 1;

  typedef logic [NUM_CH-1:0] ch_flags_t;
endpackage

// File: rtl/ocm_threshold.sv
module ocm_threshold
  import ocm_pkg::*;
#(
  parameter int CUR_W   = 12,
  parameter int TRIP_MA = 450
) (
  input  logic [NUM_CH-1:0][CUR_W-1:0] cur_ma,
  output ch_flags_t                    over,
  output logic                         any_over
);
  localparam logic [CUR_W-1:0] TRIP_V = CUR_W'(TRIP_MA);

  // one strict comparator per channel (R2)
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
    assign over[ch] = cur_ma[ch] > TRIP_V;
  end

  assign any_over = |over;
endmodule

// File: rtl/ocm_persist.sv
module ocm_persist #(
  parameter int PERSIST_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic any_over,
  output logic expire
);
  localparam int CW = $clog2(PERSIST_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(PERSIST_CYC - 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic          clear_beat;

  assign clear_beat = accept && !any_over;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (clear_beat) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (accept && !run_q) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = run_q && (cnt_q == LAST) && !clear_beat;

  assert_count_capped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_inlimit_ends_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_beat |=> !run_q && !expire);
  assert_gap_keeps_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !accept) |=> run_q);
endmodule

// File: rtl/ocm_hold.sv
module ocm_hold
  import ocm_pkg::*;
#(
  parameter int RECOVER_N = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  logic      any_over,
  input  ch_flags_t flags,
  input  logic      expire,
  output logic      fault_q,
  output ch_flags_t src_q
);
  localparam int RW = $clog2(RECOVER_N + 1);
  localparam logic [RW-1:0] REC_LAST = RW'(RECOVER_N - 1);

  ch_flags_t     last_q;
  logic [RW-1:0] rec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= '0;
    else if (accept) last_q <= flags;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      src_q   <= '0;
      rec_q   <= '0;
    end else if (!fault_q) begin
      if (expire) begin
        fault_q <= 1'b1;
        src_q   <= last_q;
        rec_q   <= '0;
      end
    end else if (accept) begin
      if (any_over) begin
        rec_q <= '0;
      end else if (rec_q == REC_LAST) begin
        fault_q <= 1'b0;
        src_q   <= '0;
        rec_q   <= '0;
      end else begin
        rec_q <= rec_q + 1'b1;
      end
    end
  end

  assert_rec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_q <= REC_LAST);
  assert_fall_on_inlimit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> $past(accept && !any_over));
  assert_rise_on_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(expire));
  assert_src_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> src_q != '0);
endmodule

// File: rtl/overcurrent_monitor.sv
module overcurrent_monitor
  import ocm_pkg::*;
#(
  parameter int CUR_W       = 12,
  parameter int TRIP_MA     = 450,
  parameter int PERSIST_CYC = 50_000_000,
  parameter int RECOVER_N   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [CUR_W-1:0] sin_ma,
  input  logic [CUR_W-1:0] cos_ma,
  output logic             health_ok,
  output logic [1:0]       fault_src
);
  logic                         rdy_q;
  logic                         seen_q;
  logic                         accept;
  logic [NUM_CH-1:0][CUR_W-1:0] cur_ma;
  ch_flags_t                    over;
  logic                         any_over;
  logic                         expire;
  logic                         fault_q;
  ch_flags_t                    src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      if (accept) seen_q <= 1'b1;
    end
  end

  assign s_ready = rdy_q;
  assign accept  = s_valid && rdy_q;

  assign cur_ma[CH_SIN] = sin_ma;
  assign cur_ma[CH_COS] = cos_ma;

  ocm_threshold #(.CUR_W(CUR_W), .TRIP_MA(TRIP_MA)) u_thr (
    .cur_ma   (cur_ma),
    .over     (over),
    .any_over (any_over)
  );

  ocm_persist #(.PERSIST_CYC(PERSIST_CYC)) u_persist (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .any_over (any_over),
    .expire   (expire)
  );

  ocm_hold #(.RECOVER_N(RECOVER_N)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .any_over (any_over),
    .flags    (over),
    .expire   (expire),
    .fault_q  (fault_q),
    .src_q    (src_q)
  );

  assign health_ok = !fault_q;
  assign fault_src = src_q;

  assert_ready_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s_ready) |-> s_ready);
  assert_idle_healthy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> health_ok);
  assert_src_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    health_ok == (fault_src == 2'b00));
endmodule

// File: tb/overcurrent_monitor_test.sv
module overcurrent_monitor_test;
  localparam int CW = 12;
  localparam int P  = 20;
  localparam int N  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [CW-1:0] sin_ma = '0;
  logic [CW-1:0] cos_ma = '0;
  logic          health_ok;
  logic [1:0]    fault_src;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int         due;
    logic       h;
    logic [1:0] src;
    string      tag;
  } exp_t;
  exp_t exq[$];

  overcurrent_monitor #(.CUR_W(CW), .TRIP_MA(450), .PERSIST_CYC(P), .RECOVER_N(N)) uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .sin_ma(sin_ma), .cos_ma(cos_ma), .health_ok(health_ok), .fault_src(fault_src)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic expect_at(input int due, input logic h, input logic [1:0] src, input string tag);
    exp_t e;
    e.due = due; e.h = h; e.src = src; e.tag = tag;
    exq.push_back(e);
  endtask

  // monitor: pops items when their cycle is reached
  always @(negedge clk) begin
    while (exq.size() > 0 && exq[0].due == cyc) begin
      exp_t e;
      e = exq.pop_front();
      chk(health_ok === e.h, {e.tag, " health_ok"}, int'(health_ok), int'(e.h));
      chk(fault_src === e.src, {e.tag, " fault_src"}, int'(fault_src), int'(e.src));
    end
  end

  // called at a negedge; beat accepted at the next posedge
  task automatic send(input int s, input int c);
    s_valid = 1'b1; sin_ma = CW'(s); cos_ma = CW'(c);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain;
    wait (exq.size() == 0);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    int c;
    @(negedge clk);
    chk(s_ready === 1'b0, "R1 ready low in reset", int'(s_ready), 0);
    chk(health_ok === 1'b1, "R7 health in reset", int'(health_ok), 1);
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready === 1'b1, "R1 ready after reset", int'(s_ready), 1);
    chk(fault_src === 2'b00, "R7 src idle", int'(fault_src), 0);

    // R1: over-limit data without valid is ignored
    sin_ma = CW'(999); cos_ma = CW'(999);
    c = cyc;
    expect_at(c + P + 5, 1'b1, 2'b00, "R1 invalid data ignored");
    expect_at(c + 2 * P, 1'b1, 2'b00, "R7 no beats healthy");
    drain();

    // R2: exactly at threshold is in limit
    c = cyc;
    send(450, 450);
    expect_at(c + P + 3, 1'b1, 2'b00, "R2 450 in limit");
    drain();
    send(0, 0);

    // R2/R3/R8: sine 451 trips after exactly P edges
    c = cyc;
    send(451, 0);
    expect_at(c + P, 1'b1, 2'b00, "R3 not yet tripped");
    expect_at(c + P + 1, 1'b0, 2'b01, "R3 trip on time sine R8");
    idle(5);
    send(600, 0); // does not restart the run
    drain();

    // R6: recovery with tally reset by overload
    send(0, 0);
    send(0, 0);
    send(700, 0);
    send(0, 0);
    send(0, 0);
    chk(health_ok === 1'b0, "R6 tally reset by overload", int'(health_ok), 0);
    c = cyc;
    send(0, 0);
    chk(health_ok === 1'b1, "R6 recovered on Nth beat", int'(health_ok), 1);
    chk(fault_src === 2'b00, "R8 src cleared", int'(fault_src), 0);

    // R4: short overload ignored
    c = cyc;
    send(0, 900);
    idle(P - 5);
    send(0, 0);
    expect_at(c + 2 * P, 1'b1, 2'b00, "R4 short overload ignored");
    drain();

    // R9: fresh run needs full period; cosine flag
    c = cyc;
    send(0, 900);
    expect_at(c + P, 1'b1, 2'b00, "R9 full period needed");
    expect_at(c + P + 1, 1'b0, 2'b10, "R9 trip cosine R8");
    drain();

    // R6: no recovery without beats
    idle(40);
    chk(health_ok === 1'b0, "R6 stays low without beats", int'(health_ok), 0);
    repeat (N) send(0, 0);
    chk(health_ok === 1'b1, "R6 recovered", int'(health_ok), 1);

    // R5: run timing continues through a gap; both channels flagged
    c = cyc;
    send(500, 500);
    expect_at(c + P, 1'b1, 2'b00, "R5 gap before due");
    expect_at(c + P + 1, 1'b0, 2'b11, "R5 gap trip both R8");
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule